// File: doc/BRIEF.md
# Tiled Texel Address Generator

This block turns a texel request (base address, integer coordinates u and v, buffer width in texels, texel size and a layout flag) into the memory byte address of the texel together with a byte-lane offset and a nibble-high flag. Two layouts are supported. The plain layout is row-major. The tiled layout groups the texture into blocks 16 bytes wide and 8 rows tall, and each block holds 32 words. The address side is purely combinational, so a fetch unit can present the address to memory in the same cycle as the request.

A second path handles the data coming back from memory. The caller returns the 32-bit word together with the size, lane, nibble flag and null-base marker that were used for the request. One cycle later the block presents the raw texel, zero-extended to 32 bits. A request whose base address was zero always yields a zero texel. Size codes that are not defined raise an error flag on both paths and produce zeros.

Top module: `texel_addr_gen`

## Requirements
- R1: Size code 1 is 8-bit, 2 is 16-bit and 3 is 32-bit. For these codes in the plain layout (swz_en_i=0), addr_o = base + (u + v*bufw) * bytes_per_texel, lane_o = 0 and nib_hi_o = 0.
- R2: Size code 0 is 4-bit. In the plain layout, addr_o = base + floor(u/2) + floor(v*bufw/2), lane_o = 0 and nib_hi_o equals bit 0 of u.
- R3: In the tiled layout with 8/16/32-bit texels, let c = u*bytes_per_texel be the byte column. Then addr_o = base + 4*((v mod 8)*4 + (c/4 mod 4) + (c/16)*32) + (v/8)*8*bufw*bytes_per_texel.
- R4: In the tiled layout the lane is 0 for 32-bit texels, (u mod 2)*2 for 16-bit texels and u mod 4 for 8-bit texels. nib_hi_o is 0 for all three sizes.
- R5: In the tiled layout with 4-bit texels, the byte column is floor(u/2) and the band term is (v/8)*4*bufw. The address uses the R3 word-offset formula. lane_o = (u mod 8)/2 and nib_hi_o equals bit 0 of u.
- R6: Size codes 4 to 7 are unsupported. With such a code, addr_err_o = 1 and addr_o, lane_o and nib_hi_o are 0. A response carrying such a code gives texel_o = 0 and tex_err_o = 1.
- R7: tex_valid_o is rsp_valid_i delayed by one clock. On a valid response, texel_o is the texel taken from rsp_word_i shifted right by 8*rsp_lane_i. It is zero-extended: 32-bit uses the whole word, 16-bit the low 16 bits, 8-bit the low 8 bits, and 4-bit bits [7:4] when rsp_hi_i=1 and bits [3:0] otherwise. Without a valid response, texel_o and tex_err_o hold their values.
- R8: A valid response with rsp_null_i = 1 gives texel_o = 0, whatever the word.
- R9: During reset, tex_valid_o, texel_o and tex_err_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_i | input | 32 | Texture base byte address |
| u_i | input | 10 | Texel column |
| v_i | input | 10 | Texel row |
| bufw_i | input | 11 | Buffer width in texels |
| size_i | input | 3 | Texel size code of the request |
| swz_en_i | input | 1 | 1 selects the tiled layout |
| addr_o | output | 32 | Byte address to fetch |
| lane_o | output | 2 | Byte lane within the fetched word |
| nib_hi_o | output | 1 | Upper nibble holds the 4-bit texel |
| addr_err_o | output | 1 | Unsupported size on the request |
| rsp_valid_i | input | 1 | Returned word is valid |
| rsp_word_i | input | 32 | Returned memory word |
| rsp_size_i | input | 3 | Size code echoed with the response |
| rsp_lane_i | input | 2 | Lane echoed with the response |
| rsp_hi_i | input | 1 | Nibble flag echoed with the response |
| rsp_null_i | input | 1 | Base of this fetch was zero |
| tex_valid_o | output | 1 | Texel output valid |
| texel_o | output | 32 | Zero-extended raw texel |
| tex_err_o | output | 1 | Response carried an unsupported size |

## Verification
The bench picks coordinates that cross tile edges: u steps across a 16-byte column boundary and v crosses row 8. A design that mixed up the in-tile word index with the band term would then land on the wrong word, one tile away. Odd and even columns of 4-bit texels are checked in both layouts. A design that truncated v*bufw before halving, or that inverted the nibble choice, would return the neighbouring texel. The response path is checked in every lane for every size, and with a null base and with undefined size codes. A wrong shift or mask there would leak bits from adjacent texels, and a missing null guard would pass memory garbage through.

// File: rtl/texaddr_pkg.sv
package texaddr_pkg;

    typedef enum logic [2:0] {
        SZ_4  = 3'd0,
        SZ_8  = 3'd1,
        SZ_16 = 3'd2,
        SZ_32 = 3'd3
    } texsz_e;

    function automatic logic size_ok(input logic [2:0] code);
        return code <= 3'd3;
    endfunction

    // log2 of texels per 32-bit word: 0 for 32-bit .. 3 for 4-bit
    function automatic logic [1:0] per_word_log2(input logic [2:0] code);
        return 2'd3 - code[1:0];
    endfunction

    typedef struct packed {
        logic        valid;
        logic [31:0] texel;
        logic        err;
    } ext_st_t;

endpackage

// File: rtl/texaddr_linear.sv
module texaddr_linear
    import texaddr_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int COORD_W = 10,
    parameter int BUFW_W  = 11
) (
    input  logic [ADDR_W-1:0]  base_i,
    input  logic [COORD_W-1:0] u_i,
    input  logic [COORD_W-1:0] v_i,
    input  logic [BUFW_W-1:0]  bufw_i,
    input  logic [2:0]         size_i,
    output logic [ADDR_W-1:0]  addr_o,
    output logic [1:0]         lane_o,
    output logic               nib_hi_o
);
    logic [ADDR_W-1:0] u_x, v_x, w_x, row_x, idx_x;

    always_comb begin
        u_x      = ADDR_W'(u_i);
        v_x      = ADDR_W'(v_i);
        w_x      = ADDR_W'(bufw_i);
        row_x    = v_x * w_x;
        idx_x    = u_x + row_x;
        lane_o   = 2'd0;
        nib_hi_o = 1'b0;
        case (size_i)
            SZ_4: begin
                addr_o   = base_i + (u_x >> 1) + (row_x >> 1);
                nib_hi_o = u_i[0];
            end
            SZ_8:    addr_o = base_i + idx_x;
            SZ_16:   addr_o = base_i + (idx_x << 1);
            SZ_32:   addr_o = base_i + (idx_x << 2);
            default: addr_o = '0;
        endcase
    end

endmodule

// File: rtl/texaddr_tiled.sv
module texaddr_tiled
    import texaddr_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int COORD_W   = 10,
    parameter int BUFW_W    = 11,
    parameter int TILE_ROWS = 8
) (
    input  logic [ADDR_W-1:0]  base_i,
    input  logic [COORD_W-1:0] u_i,
    input  logic [COORD_W-1:0] v_i,
    input  logic [BUFW_W-1:0]  bufw_i,
    input  logic [2:0]         size_i,
    output logic [ADDR_W-1:0]  addr_o,
    output logic [1:0]         lane_o,
    output logic               nib_hi_o
);
    localparam int ROW_BITS  = $clog2(TILE_ROWS);
    localparam int WORDS_ROW = 4;                      // 16-byte tile row
    localparam int TILE_WRDS = TILE_ROWS * WORDS_ROW;  // words per tile
    localparam int TILE_SH   = $clog2(TILE_WRDS);

    logic [ADDR_W-1:0] u_x, w_x, band_rows, wcol, word_off, band;
    logic [1:0]        shift_s;

    always_comb begin
        u_x       = ADDR_W'(u_i);
        w_x       = ADDR_W'(bufw_i);
        shift_s   = per_word_log2(size_i);
        band_rows = ADDR_W'(v_i >> ROW_BITS) * w_x;
        case (shift_s)
            2'd0:    wcol = u_x;
            2'd1:    wcol = u_x >> 1;
            2'd2:    wcol = u_x >> 2;
            default: wcol = u_x >> 3;
        endcase
        word_off = ADDR_W'({v_i[ROW_BITS-1:0], 2'b00})
                 + ADDR_W'(wcol[1:0])
                 + ((wcol >> 2) << TILE_SH);
        // band bytes = rows * TILE_ROWS * bufw * bits/8
        case (shift_s)
            2'd0:    band = band_rows << (ROW_BITS + 2);
            2'd1:    band = band_rows << (ROW_BITS + 1);
            2'd2:    band = band_rows << ROW_BITS;
            default: band = band_rows << (ROW_BITS - 1);
        endcase
        nib_hi_o = 1'b0;
        case (size_i)
            SZ_4: begin
                lane_o   = u_i[2:1];
                nib_hi_o = u_i[0];
            end
            SZ_8:    lane_o = u_i[1:0];
            SZ_16:   lane_o = {u_i[0], 1'b0};
            default: lane_o = 2'd0;
        endcase
        addr_o = base_i + (word_off << 2) + band;
    end

endmodule

// File: rtl/texel_extract.sv
module texel_extract
    import texaddr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rsp_valid_i,
    input  logic [31:0] rsp_word_i,
    input  logic [2:0]  rsp_size_i,
    input  logic [1:0]  rsp_lane_i,
    input  logic        rsp_hi_i,
    input  logic        rsp_null_i,
    output logic        tex_valid_o,
    output logic [31:0] texel_o,
    output logic        tex_err_o
);
    ext_st_t     st_d, st_q;
    logic [31:0] shifted;

    always_comb begin
        st_d       = st_q;
        st_d.valid = rsp_valid_i;
        shifted    = rsp_word_i >> {rsp_lane_i, 3'b000};
        if (rsp_valid_i) begin
            st_d.err = !size_ok(rsp_size_i);
            case (rsp_size_i)
                SZ_4:    st_d.texel = {28'd0, rsp_hi_i ? shifted[7:4] : shifted[3:0]};
                SZ_8:    st_d.texel = {24'd0, shifted[7:0]};
                SZ_16:   st_d.texel = {16'd0, shifted[15:0]};
                SZ_32:   st_d.texel = rsp_word_i;
                default: st_d.texel = '0;
            endcase
            if (rsp_null_i) st_d.texel = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tex_valid_o = st_q.valid;
    assign texel_o     = st_q.texel;
    assign tex_err_o   = st_q.err;

    p_valid_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_i |=> tex_valid_o);
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid_i |=> !tex_valid_o && $stable(texel_o) && $stable(tex_err_o));
    p_half_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_i && rsp_size_i == SZ_16 |=> texel_o[31:16] == 16'd0);
    p_null_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_i && rsp_null_i |=> texel_o == 32'd0);
    p_bad_size_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_i && rsp_size_i[2] |=> tex_err_o && texel_o == 32'd0);

endmodule

// File: rtl/texel_addr_gen.sv
module texel_addr_gen
    import texaddr_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int COORD_W = 10,
    parameter int BUFW_W  = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  base_i,
    input  logic [COORD_W-1:0] u_i,
    input  logic [COORD_W-1:0] v_i,
    input  logic [BUFW_W-1:0]  bufw_i,
    input  logic [2:0]         size_i,
    input  logic               swz_en_i,
    output logic [ADDR_W-1:0]  addr_o,
    output logic [1:0]         lane_o,
    output logic               nib_hi_o,
    output logic               addr_err_o,
    input  logic               rsp_valid_i,
    input  logic [31:0]        rsp_word_i,
    input  logic [2:0]         rsp_size_i,
    input  logic [1:0]         rsp_lane_i,
    input  logic               rsp_hi_i,
    input  logic               rsp_null_i,
    output logic               tex_valid_o,
    output logic [31:0]        texel_o,
    output logic               tex_err_o
);
    logic [ADDR_W-1:0] lin_addr, til_addr;
    logic [1:0]        lin_lane, til_lane;
    logic              lin_hi, til_hi;

    texaddr_linear #(.ADDR_W(ADDR_W), .COORD_W(COORD_W), .BUFW_W(BUFW_W)) u_lin (
        .base_i(base_i), .u_i(u_i), .v_i(v_i), .bufw_i(bufw_i), .size_i(size_i),
        .addr_o(lin_addr), .lane_o(lin_lane), .nib_hi_o(lin_hi)
    );

    texaddr_tiled #(.ADDR_W(ADDR_W), .COORD_W(COORD_W), .BUFW_W(BUFW_W)) u_til (
        .base_i(base_i), .u_i(u_i), .v_i(v_i), .bufw_i(bufw_i), .size_i(size_i),
        .addr_o(til_addr), .lane_o(til_lane), .nib_hi_o(til_hi)
    );

    always_comb begin
        addr_err_o = !size_ok(size_i);
        if (addr_err_o) begin
            addr_o   = '0;
            lane_o   = 2'd0;
            nib_hi_o = 1'b0;
        end else if (swz_en_i) begin
            addr_o   = til_addr;
            lane_o   = til_lane;
            nib_hi_o = til_hi;
        end else begin
            addr_o   = lin_addr;
            lane_o   = lin_lane;
            nib_hi_o = lin_hi;
        end
    end

    texel_extract u_ext (
        .clk(clk), .rst_n(rst_n),
        .rsp_valid_i(rsp_valid_i), .rsp_word_i(rsp_word_i), .rsp_size_i(rsp_size_i),
        .rsp_lane_i(rsp_lane_i), .rsp_hi_i(rsp_hi_i), .rsp_null_i(rsp_null_i),
        .tex_valid_o(tex_valid_o), .texel_o(texel_o), .tex_err_o(tex_err_o)
    );

    p_plain_lane_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !swz_en_i && size_i inside {SZ_8, SZ_16, SZ_32} |-> lane_o == 2'd0 && !nib_hi_o);
    p_tiled_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
        swz_en_i && size_i == SZ_16 |-> lane_o[0] == 1'b0 && lane_o[1] == u_i[0]);
    p_nibble_r5: assert property (@(posedge clk) disable iff (!rst_n)
        size_i == SZ_4 |-> nib_hi_o == u_i[0]);
    p_err_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        size_i[2] |-> addr_err_o && addr_o == '0 && lane_o == 2'd0);

endmodule

// File: tb/sim_texel_addr_gen.sv
module sim_texel_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] base_i = '0;
    logic [9:0]  u_i = '0, v_i = '0;
    logic [10:0] bufw_i = '0;
    logic [2:0]  size_i = '0;
    logic        swz_en_i = 1'b0;
    logic [31:0] addr_o;
    logic [1:0]  lane_o;
    logic        nib_hi_o, addr_err_o;
    logic        rsp_valid_i = 1'b0;
    logic [31:0] rsp_word_i = '0;
    logic [2:0]  rsp_size_i = '0;
    logic [1:0]  rsp_lane_i = '0;
    logic        rsp_hi_i = 1'b0, rsp_null_i = 1'b0;
    logic        tex_valid_o, tex_err_o;
    logic [31:0] texel_o;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    texel_addr_gen u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int bpt(input int code);
        return (code == 0) ? 4 : 8 << (code - 1);
    endfunction

    task automatic req(input logic [31:0] b, input int u, input int v, input int w,
                       input int code, input logic swz);
        @(negedge clk);
        base_i = b; u_i = 10'(u); v_i = 10'(v); bufw_i = 11'(w);
        size_i = 3'(code); swz_en_i = swz;
        #1;
    endtask

    task automatic t_plain_wide;
        for (int code = 1; code <= 3; code++) begin
            for (int k = 0; k < 3; k++) begin
                int u = 5 + 17 * k, v = 3 + 9 * k, w = 64 + 8 * k;
                req(32'h0010_0000, u, v, w, code, 1'b0);
                chk("R1 addr", addr_o, 32'h0010_0000 + (u + v * w) * (bpt(code) / 8));
                chk("R1 lane", {30'd0, lane_o}, 0);
            end
        end
    endtask

    task automatic t_plain_nib;
        for (int u = 6; u <= 7; u++) begin
            req(32'h2000, u, 3, 33, 0, 1'b0);
            chk("R2 addr", addr_o, 32'h2000 + u / 2 + (3 * 33) / 2);
            chk("R2 nibble", {31'd0, nib_hi_o}, u % 2);
        end
    endtask

    function automatic int tiled_addr(input int b, input int u, input int v, input int w, input int code);
        int c   = (code == 0) ? u / 2 : u * (bpt(code) / 8);
        int off = (v % 8) * 4 + (c / 4) % 4 + (c / 16) * 32;
        return b + 4 * off + (v / 8) * 8 * w * bpt(code) / 8;
    endfunction

    task automatic t_tiled_wide;
        int us[4] = '{3, 4, 13, 37};
        int vs[4] = '{0, 7, 8, 21};
        for (int code = 1; code <= 3; code++) begin
            for (int k = 0; k < 4; k++) begin
                int u = us[k], v = vs[k];
                int lane = (code == 3) ? 0 : (code == 2) ? (u % 2) * 2 : u % 4;
                req(32'h0040_0000, u, v, 128, code, 1'b1);
                chk("R3 addr", addr_o, tiled_addr(32'h0040_0000, u, v, 128, code));
                chk("R4 lane", {30'd0, lane_o}, lane);
                chk("R4 nibble", {31'd0, nib_hi_o}, 0);
            end
        end
    endtask

    task automatic t_tiled_nib;
        int us[4] = '{0, 5, 31, 33};
        for (int k = 0; k < 4; k++) begin
            int u = us[k], v = 9 + k;
            req(32'h800, u, v, 256, 0, 1'b1);
            chk("R5 addr", addr_o, tiled_addr(32'h800, u, v, 256, 0));
            chk("R5 lane", {30'd0, lane_o}, (u % 8) / 2);
            chk("R5 nibble", {31'd0, nib_hi_o}, u % 2);
        end
    endtask

    task automatic t_bad_size;
        for (int code = 4; code <= 7; code += 3) begin
            req(32'h1234, 7, 7, 64, code, code[0]);
            chk("R6 err", {31'd0, addr_err_o}, 1);
            chk("R6 addr", addr_o, 0);
            chk("R6 lane", {29'd0, nib_hi_o, lane_o}, 0);
        end
        req(32'h1234, 7, 7, 64, 2, 1'b0);
        chk("R6 no err", {31'd0, addr_err_o}, 0);
    endtask

    task automatic rsp(input logic [31:0] word, input int code, input int lane,
                       input logic hi, input logic nul);
        @(negedge clk);
        rsp_valid_i = 1'b1; rsp_word_i = word; rsp_size_i = 3'(code);
        rsp_lane_i = 2'(lane); rsp_hi_i = hi; rsp_null_i = nul;
        @(negedge clk);
        rsp_valid_i = 1'b0;
    endtask

    task automatic t_extract;
        logic [31:0] w = 32'hA1B2_C3D4;
        rsp(w, 3, 0, 1'b0, 1'b0);
        chk("R7 valid", {31'd0, tex_valid_o}, 1);
        chk("R7 32b", texel_o, w);
        for (int l = 0; l < 4; l++) begin
            rsp(w, 1, l, 1'b0, 1'b0);
            chk("R7 8b", texel_o, (w >> (8 * l)) & 32'hFF);
        end
        for (int l = 0; l < 4; l += 2) begin
            rsp(w, 2, l, 1'b0, 1'b0);
            chk("R7 16b", texel_o, (w >> (8 * l)) & 32'hFFFF);
        end
        for (int l = 0; l < 4; l++) begin
            rsp(w, 0, l, 1'b1, 1'b0);
            chk("R7 4b hi", texel_o, (w >> (8 * l + 4)) & 32'hF);
            rsp(w, 0, l, 1'b0, 1'b0);
            chk("R7 4b lo", texel_o, (w >> (8 * l)) & 32'hF);
        end
        rsp(32'h0000_BEEF, 2, 0, 1'b0, 1'b0);
        @(negedge clk);
        chk("R7 valid drop", {31'd0, tex_valid_o}, 0);
        chk("R7 hold", texel_o, 32'hBEEF);
    endtask

    task automatic t_null_and_err;
        rsp(32'hFFFF_FFFF, 3, 0, 1'b0, 1'b1);
        chk("R8 null 32b", texel_o, 0);
        rsp(32'hFFFF_FFFF, 0, 2, 1'b1, 1'b1);
        chk("R8 null 4b", texel_o, 0);
        rsp(32'hFFFF_FFFF, 5, 1, 1'b0, 1'b0);
        chk("R6 rsp err", {31'd0, tex_err_o}, 1);
        chk("R6 rsp texel", texel_o, 0);
        rsp(32'h55, 1, 0, 1'b0, 1'b0);
        chk("R6 err clears", {31'd0, tex_err_o}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R9 valid", {31'd0, tex_valid_o}, 0);
        chk("R9 texel", texel_o, 0);
        chk("R9 err", {31'd0, tex_err_o}, 0);
        rst_n = 1'b1;
        t_plain_wide();
        t_plain_nib();
        t_tiled_wide();
        t_tiled_nib();
        t_bad_size();
        t_extract();
        t_null_and_err();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule